// File: doc/BRIEF.md
# Clock recovery frequency error trimmer

This block measures how far a free-running internal oscillator drifts from an external reference. The reference is a periodic one-cycle SYNC pulse, and the oscillator produces the block's clock. Each SYNC loads a reload value into a frequency error counter. The counter counts down to zero, which is the point where the next SYNC is expected, and from there it counts up. At the next SYNC the counter holds the error magnitude, and its direction tells which side of the target the oscillator sits on.

On each SYNC the block captures the error and its direction. It sorts the error into one of three classes, using 3x and 128x multiples of a programmable limit. When automatic trimming is on, it moves a 7-bit trim code by one or two steps toward the target. A SYNC that arrives too early, a SYNC that never arrives, and a trim code pushed past either end of its range each set their own sticky error flag. A summary error flag covers all three.

Each flag has its own interrupt enable, and a single interrupt output combines the enabled flags. Write-one-to-clear strobes reset the flags. The first SYNC after reset only starts the counter and produces no measurement.

Top module: `clk_recovery_trimmer`

## Requirements
- R1: The first SYNC after reset only loads the counter. It sets no class flag, leaves the trim code at 64 and leaves the capture at 0 and the direction at 0.
- R2: Every later SYNC latches the counter value into `err_cap_o` and the direction into `err_dir_o`. Direction 1 means the counter was still counting down, so the oscillator is slow. Direction 0 means it was counting up, so the oscillator is fast. The error equals |cycles between SYNC edges - 1 - reload|.
- R3: An error below 3x the limit sets the OK flag. With auto-trim on and a nonzero error, the trim moves one step: up for direction 1, down for direction 0. A zero error leaves the trim unchanged.
- R4: An error of at least 3x and below 128x the limit sets the warning flag. With auto-trim on, the trim moves two steps in the direction given in R3.
- R5: The expected-SYNC flag sets in the cycle after the down-counting counter holds zero without a SYNC. The counter then counts up.
- R6: A SYNC taken while counting down with an error of at least 128x the limit sets the SYNC-error flag. The trim does not change.
- R7: When the up-counting counter reaches 128x the limit without a SYNC, the SYNC-missed flag sets and the counter holds its value until the next SYNC. That SYNC captures 128x the limit with direction 0 and does not change the trim.
- R8: The trim code saturates at 127 and at 0. A step that would pass either bound sets the trim-overflow flag.
- R9: Flags are sticky until cleared. `err_flag_o` is the OR of the SYNC-error, SYNC-missed and trim-overflow flags, and `err_clr_i` clears all three. A set takes priority over a clear in the same cycle.
- R10: `irq_o` is high when any flag is set together with its enable. A set flag whose enable is low does not raise it.
- R11: With `auto_trim_i` low, a SYNC classifies and captures the error but leaves the trim unchanged.
- R12: After reset the trim is 64 and all flags, the capture and the direction are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | One-cycle reference SYNC pulse |
| reload_i | input | CNT_W | Counter reload value |
| limit_i | input | LIM_W | Error limit unit |
| auto_trim_i | input | 1 | Enable automatic trim updates |
| ok_ie_i | input | 1 | OK flag interrupt enable |
| warn_ie_i | input | 1 | Warning flag interrupt enable |
| exp_ie_i | input | 1 | Expected-SYNC flag interrupt enable |
| err_ie_i | input | 1 | Summary error interrupt enable |
| ok_clr_i | input | 1 | Clear OK flag |
| warn_clr_i | input | 1 | Clear warning flag |
| exp_clr_i | input | 1 | Clear expected-SYNC flag |
| err_clr_i | input | 1 | Clear all three error flags |
| trim_o | output | TRIM_W | Oscillator trim code |
| ok_flag_o | output | 1 | OK class flag |
| warn_flag_o | output | 1 | Warning class flag |
| exp_flag_o | output | 1 | Expected-SYNC flag |
| err_flag_o | output | 1 | Summary error flag |
| sync_err_o | output | 1 | Early SYNC error flag |
| sync_miss_o | output | 1 | Missed SYNC flag |
| trim_ovf_o | output | 1 | Trim saturation flag |
| err_cap_o | output | CNT_W | Captured error value |
| err_dir_o | output | 1 | Captured counting direction |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the block with CNT_W=16, LIM_W=8, TRIM_W=7 and TRIM_RST=64, and drives a reload of 40 and a limit of 2. This sets the class thresholds at 6 and 256, so every class boundary, the expected-SYNC point and the missed-SYNC halt fall within a few hundred cycles. Separate runs raise the reload to 300 to produce an early-SYNC error. The 7-bit trim lets repeated two-step warnings drive the code to both saturation limits in under a hundred SYNC periods.

// File: rtl/crs_trim_pkg.sv
package crs_trim_pkg;
  typedef enum logic [1:0] {
    CLS_OK   = 2'd0,
    CLS_WARN = 2'd1,
    CLS_BIG  = 2'd2
  } err_class_e;

  localparam int NFLAG   = 6;
  localparam int FL_OK   = 0;
  localparam int FL_WARN = 1;
  localparam int FL_EXP  = 2;
  localparam int FL_SERR = 3;
  localparam int FL_MISS = 4;
  localparam int FL_OVF  = 5;
endpackage

// File: rtl/crs_err_counter.sv
module crs_err_counter #(
  parameter int CNT_W = 16,
  parameter int LIM_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sync_i,
  input  logic [CNT_W-1:0]     reload_i,
  input  logic [LIM_W+6:0]     lim128_i,
  output logic [CNT_W-1:0]     cnt_o,
  output logic                 down_o,
  output logic                 armed_o,
  output logic                 exp_evt_o,
  output logic                 miss_evt_o
);
  localparam int CW = ((CNT_W > LIM_W + 7) ? CNT_W : LIM_W + 7) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic             down_q, halted_q, armed_q;
  logic             at_lim;

  assign at_lim     = CW'(cnt_q) >= CW'(lim128_i);
  assign exp_evt_o  = armed_q && !sync_i && !halted_q && down_q && (cnt_q == '0);
  assign miss_evt_o = armed_q && !sync_i && !halted_q && !down_q && at_lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      down_q   <= 1'b0;
      halted_q <= 1'b0;
      armed_q  <= 1'b0;
    end else if (sync_i) begin
      cnt_q    <= reload_i;
      down_q   <= 1'b1;
      halted_q <= 1'b0;
      armed_q  <= 1'b1;
    end else if (armed_q && !halted_q) begin
      if (down_q) begin
        if (cnt_q == '0) begin
          down_q <= 1'b0;
          cnt_q  <= CNT_W'(1);
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end else if (at_lim) begin
        halted_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign cnt_o   = cnt_q;
  assign down_o  = down_q;
  assign armed_o = armed_q;

  // R7: a halted counter keeps its value until SYNC
  a_r7_halt_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_q && !sync_i) |=> $stable(cnt_q));
  // R5: reaching zero turns the counter upward
  a_r5_exp_turns_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_evt_o |=> !down_q);
endmodule

// File: rtl/crs_classifier.sv
module crs_classifier
  import crs_trim_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LIM_W = 8
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic [LIM_W+6:0] lim128_o,
  output err_class_e       cls_o,
  output logic [1:0]       step_o
);
  localparam int CW = ((CNT_W > LIM_W + 7) ? CNT_W : LIM_W + 7) + 1;

  logic [CW-1:0] cnt_w, lim3_w, lim128_w;

  assign cnt_w    = CW'(cnt_i);
  assign lim3_w   = CW'(limit_i) + CW'({limit_i, 1'b0});
  assign lim128_w = CW'({limit_i, 7'b0});
  assign lim128_o = {limit_i, 7'b0};

  always_comb begin
    if (cnt_w < lim3_w) begin
      cls_o  = CLS_OK;
      step_o = (cnt_i != '0) ? 2'd1 : 2'd0;
    end else if (cnt_w < lim128_w) begin
      cls_o  = CLS_WARN;
      step_o = 2'd2;
    end else begin
      cls_o  = CLS_BIG;
      step_o = 2'd0;
    end
  end
endmodule

// File: rtl/crs_trim_unit.sv
module crs_trim_unit #(
  parameter int TRIM_W   = 7,
  parameter int TRIM_RST = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic              raise_i,
  input  logic [1:0]        step_i,
  output logic [TRIM_W-1:0] trim_o,
  output logic              ovf_o
);
  logic [TRIM_W-1:0] trim_q, trim_d;
  logic [TRIM_W:0]   sum_w;
  logic              over, under;

  assign sum_w = {1'b0, trim_q} + {{(TRIM_W-1){1'b0}}, step_i};
  assign over  = sum_w[TRIM_W];
  assign under = trim_q < TRIM_W'(step_i);

  always_comb begin
    if (raise_i) trim_d = over  ? '1 : sum_w[TRIM_W-1:0];
    else         trim_d = under ? '0 : trim_q - TRIM_W'(step_i);
  end

  assign ovf_o = upd_i && (raise_i ? over : under);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    trim_q <= TRIM_W'(TRIM_RST);
    else if (upd_i) trim_q <= trim_d;
  end

  assign trim_o = trim_q;

  // R11: trim only moves on an update request
  a_r11_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(trim_q));
  // R8: no update moves the trim by more than two codes
  a_r8_step_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((int'($past(trim_q)) + 2 >= int'(trim_q)) &&
              (int'(trim_q) + 2 >= int'($past(trim_q)))));
endmodule

// File: rtl/crs_flag_bank.sv
module crs_flag_bank #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q <= 1'b0;
      else if (set_i[i]) flag_q <= 1'b1;
      else if (clr_i[i]) flag_q <= 1'b0;
    end
    assign flag_o[i] = flag_q;

    // R9: flags hold until cleared
    a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q && !clr_i[i]) |=> flag_q);
  end
endmodule

// File: rtl/clk_recovery_trimmer.sv
module clk_recovery_trimmer
  import crs_trim_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int LIM_W    = 8,
  parameter int TRIM_W   = 7,
  parameter int TRIM_RST = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic [CNT_W-1:0]  reload_i,
  input  logic [LIM_W-1:0]  limit_i,
  input  logic              auto_trim_i,
  input  logic              ok_ie_i,
  input  logic              warn_ie_i,
  input  logic              exp_ie_i,
  input  logic              err_ie_i,
  input  logic              ok_clr_i,
  input  logic              warn_clr_i,
  input  logic              exp_clr_i,
  input  logic              err_clr_i,
  output logic [TRIM_W-1:0] trim_o,
  output logic              ok_flag_o,
  output logic              warn_flag_o,
  output logic              exp_flag_o,
  output logic              err_flag_o,
  output logic              sync_err_o,
  output logic              sync_miss_o,
  output logic              trim_ovf_o,
  output logic [CNT_W-1:0]  err_cap_o,
  output logic              err_dir_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] cnt;
  logic [LIM_W+6:0] lim128;
  logic             down, armed, exp_evt, miss_evt;
  err_class_e       cls;
  logic [1:0]       step;
  logic             meas, upd, ovf_evt;
  logic [NFLAG-1:0] set_vec, clr_vec, flags, ie_vec;
  logic [CNT_W-1:0] cap_q;
  logic             dir_q;

  crs_err_counter #(.CNT_W(CNT_W), .LIM_W(LIM_W)) u_cnt (
    .clk_i, .rst_ni, .sync_i, .reload_i,
    .lim128_i  (lim128),
    .cnt_o     (cnt),
    .down_o    (down),
    .armed_o   (armed),
    .exp_evt_o (exp_evt),
    .miss_evt_o(miss_evt)
  );

  crs_classifier #(.CNT_W(CNT_W), .LIM_W(LIM_W)) u_cls (
    .cnt_i   (cnt),
    .limit_i,
    .lim128_o(lim128),
    .cls_o   (cls),
    .step_o  (step)
  );

  // a SYNC only measures once the counter has been started
  assign meas = sync_i && armed;
  assign upd  = meas && auto_trim_i && (cls != CLS_BIG) && (step != 2'd0);

  crs_trim_unit #(.TRIM_W(TRIM_W), .TRIM_RST(TRIM_RST)) u_trim (
    .clk_i, .rst_ni,
    .upd_i  (upd),
    .raise_i(down),
    .step_i (step),
    .trim_o,
    .ovf_o  (ovf_evt)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[FL_OK]   = meas && (cls == CLS_OK);
    set_vec[FL_WARN] = meas && (cls == CLS_WARN);
    set_vec[FL_EXP]  = exp_evt;
    set_vec[FL_SERR] = meas && (cls == CLS_BIG) && down;
    set_vec[FL_MISS] = (meas && (cls == CLS_BIG) && !down) || miss_evt;
    set_vec[FL_OVF]  = ovf_evt;
    clr_vec          = '0;
    clr_vec[FL_OK]   = ok_clr_i;
    clr_vec[FL_WARN] = warn_clr_i;
    clr_vec[FL_EXP]  = exp_clr_i;
    clr_vec[FL_SERR] = err_clr_i;
    clr_vec[FL_MISS] = err_clr_i;
    clr_vec[FL_OVF]  = err_clr_i;
    ie_vec           = '0;
    ie_vec[FL_OK]    = ok_ie_i;
    ie_vec[FL_WARN]  = warn_ie_i;
    ie_vec[FL_EXP]   = exp_ie_i;
    ie_vec[FL_SERR]  = err_ie_i;
    ie_vec[FL_MISS]  = err_ie_i;
    ie_vec[FL_OVF]   = err_ie_i;
  end

  crs_flag_bank #(.N(NFLAG)) u_flags (
    .clk_i, .rst_ni,
    .set_i (set_vec),
    .clr_i (clr_vec),
    .flag_o(flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= '0;
      dir_q <= 1'b0;
    end else if (meas) begin
      cap_q <= cnt;
      dir_q <= down;
    end
  end

  assign ok_flag_o   = flags[FL_OK];
  assign warn_flag_o = flags[FL_WARN];
  assign exp_flag_o  = flags[FL_EXP];
  assign sync_err_o  = flags[FL_SERR];
  assign sync_miss_o = flags[FL_MISS];
  assign trim_ovf_o  = flags[FL_OVF];
  assign err_flag_o  = flags[FL_SERR] | flags[FL_MISS] | flags[FL_OVF];
  assign err_cap_o   = cap_q;
  assign err_dir_o   = dir_q;
  assign irq_o       = |(flags & ie_vec);

  // R6: early SYNC error only from a SYNC taken while counting down
  a_r6_serr_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_err_o) |-> ($past(sync_i) && $past(down)));
  // R1: the starting SYNC raises no class flag
  a_r1_unarmed_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i && !armed) |=> (!$rose(ok_flag_o) && !$rose(warn_flag_o)));
  // R2: capture only changes on a SYNC
  a_r2_cap_on_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_i |=> $stable(err_cap_o));
endmodule

// File: tb/clk_recovery_trimmer_tb_top.sv
module clk_recovery_trimmer_tb_top;
  localparam int CNT_W = 16;
  localparam int LIM_W = 8;
  localparam int TRIM_W = 7;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sync_i = 1'b0;
  logic [CNT_W-1:0] reload_i = 16'd40;
  logic [LIM_W-1:0] limit_i = 8'd2;
  logic auto_trim_i = 1'b1;
  logic ok_ie_i = 0, warn_ie_i = 0, exp_ie_i = 0, err_ie_i = 0;
  logic ok_clr_i = 0, warn_clr_i = 0, exp_clr_i = 0, err_clr_i = 0;
  logic [TRIM_W-1:0] trim_o;
  logic ok_flag_o, warn_flag_o, exp_flag_o, err_flag_o;
  logic sync_err_o, sync_miss_o, trim_ovf_o, err_dir_o, irq_o;
  logic [CNT_W-1:0] err_cap_o;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  clk_recovery_trimmer #(.CNT_W(CNT_W), .LIM_W(LIM_W), .TRIM_W(TRIM_W), .TRIM_RST(64)) dut_i (
    .clk_i(clk), .rst_ni, .sync_i, .reload_i, .limit_i, .auto_trim_i,
    .ok_ie_i, .warn_ie_i, .exp_ie_i, .err_ie_i,
    .ok_clr_i, .warn_clr_i, .exp_clr_i, .err_clr_i,
    .trim_o, .ok_flag_o, .warn_flag_o, .exp_flag_o, .err_flag_o,
    .sync_err_o, .sync_miss_o, .trim_ovf_o, .err_cap_o, .err_dir_o, .irq_o
  );

  // reload 40, limit 2: OK < 6, warning < 256
  localparam int NV = 9;
  localparam int V_GAP [NV] = '{41, 39, 44, 46, 47, 30, 35, 296, 297};
  localparam int V_AUTO[NV] = '{ 1,  1,  1,  1,  1,  1,  0,   1,   1};
  localparam int V_CAP [NV] = '{ 0,  2,  3,  5,  6, 11,  6, 255, 256};
  localparam int V_DIR [NV] = '{ 1,  1,  0,  0,  0,  1,  1,   0,   0};
  localparam int V_OK  [NV] = '{ 1,  1,  1,  1,  0,  0,  0,   0,   0};
  localparam int V_WARN[NV] = '{ 0,  0,  0,  0,  1,  1,  1,   1,   0};
  localparam int V_EXP [NV] = '{ 0,  0,  1,  1,  1,  0,  0,   1,   1};
  localparam int V_MISS[NV] = '{ 0,  0,  0,  0,  0,  0,  0,   0,   1};
  localparam int V_TRIM[NV] = '{64, 65, 64, 63, 61, 63, 63,  61,  61};

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_all();
    ok_clr_i = 1; warn_clr_i = 1; exp_clr_i = 1; err_clr_i = 1;
    @(negedge clk);
    ok_clr_i = 0; warn_clr_i = 0; exp_clr_i = 0; err_clr_i = 0;
  endtask

  // SYNC edge lands g edges after the edge preceding the current negedge
  task automatic gap_sync(input int g);
    repeat (g - 1) @(negedge clk);
    sync_i = 1;
    @(negedge clk);
    sync_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12 trim after reset", int'(trim_o), 64);
    check("R12 flags after reset", int'({ok_flag_o, warn_flag_o, exp_flag_o, err_flag_o}), 0);
    check("R12 capture after reset", int'(err_cap_o), 0);
    rst_ni = 1;
    @(negedge clk);

    // arming SYNC
    gap_sync(1);
    check("R1 ok flag on first SYNC", int'(ok_flag_o), 0);
    check("R1 warn flag on first SYNC", int'(warn_flag_o), 0);
    check("R1 capture on first SYNC", int'(err_cap_o), 0);
    check("R1 trim on first SYNC", int'(trim_o), 64);

    for (int i = 0; i < NV; i++) begin
      clear_all();
      auto_trim_i = V_AUTO[i][0];
      gap_sync(V_GAP[i] - 1);
      check("R2 capture", int'(err_cap_o), V_CAP[i]);
      check("R2 direction", int'(err_dir_o), V_DIR[i]);
      check("R3 ok flag", int'(ok_flag_o), V_OK[i]);
      check("R4 warn flag", int'(warn_flag_o), V_WARN[i]);
      check("R5 expected flag", int'(exp_flag_o), V_EXP[i]);
      check("R7 missed flag", int'(sync_miss_o), V_MISS[i]);
      check("R3 R4 R11 trim", int'(trim_o), V_TRIM[i]);
    end
    auto_trim_i = 1;

    // summary flag, masking and clear
    check("R9 summary from missed", int'(err_flag_o), 1);
    check("R10 masked irq", int'(irq_o), 0);
    err_ie_i = 1;
    #1;
    check("R10 enabled irq", int'(irq_o), 1);
    err_ie_i = 0;
    err_clr_i = 1;
    @(negedge clk);
    err_clr_i = 0;
    check("R9 clear missed", int'(sync_miss_o), 0);
    check("R9 clear summary", int'(err_flag_o), 0);

    // early SYNC error with a large reload
    reload_i = 16'd300;
    auto_trim_i = 0;
    gap_sync(5);
    auto_trim_i = 1;
    clear_all();
    gap_sync(43);
    check("R6 sync error", int'(sync_err_o), 1);
    check("R6 summary", int'(err_flag_o), 1);
    check("R6 capture", int'(err_cap_o), 257);
    check("R6 trim unchanged", int'(trim_o), 61);

    // missed SYNC halts the counter
    reload_i = 16'd40;
    auto_trim_i = 0;
    gap_sync(10);
    auto_trim_i = 1;
    clear_all();
    repeat (398) @(negedge clk);
    check("R7 missed flag without SYNC", int'(sync_miss_o), 1);
    check("R5 expected flag before miss", int'(exp_flag_o), 1);
    gap_sync(1);
    check("R7 halted capture", int'(err_cap_o), 256);
    check("R7 halted direction", int'(err_dir_o), 0);
    check("R7 trim unchanged", int'(trim_o), 61);

    // saturate upward
    clear_all();
    gap_sync(29);
    for (int k = 0; k < 32; k++) gap_sync(30);
    check("R8 trim at top", int'(trim_o), 127);
    check("R8 no overflow yet", int'(trim_ovf_o), 0);
    gap_sync(30);
    check("R8 trim clamped high", int'(trim_o), 127);
    check("R8 overflow high", int'(trim_ovf_o), 1);

    // saturate downward
    clear_all();
    gap_sync(49);
    for (int k = 0; k < 62; k++) gap_sync(50);
    check("R8 trim at one", int'(trim_o), 1);
    check("R8 no underflow yet", int'(trim_ovf_o), 0);
    gap_sync(50);
    check("R8 trim clamped low", int'(trim_o), 0);
    check("R8 underflow", int'(trim_ovf_o), 1);

    // sticky warning and its interrupt
    check("R9 warn sticky", int'(warn_flag_o), 1);
    warn_ie_i = 1;
    #1;
    check("R10 warn irq", int'(irq_o), 1);
    warn_clr_i = 1;
    @(negedge clk);
    warn_clr_i = 0;
    check("R10 irq after warn clear", int'(irq_o), 0);
    warn_ie_i = 0;

    // reset mid-run, then re-arm
    rst_ni = 0;
    @(negedge clk);
    check("R12 trim after second reset", int'(trim_o), 64);
    check("R12 summary after second reset", int'(err_flag_o), 0);
    rst_ni = 1;
    @(negedge clk);
    gap_sync(1);
    check("R1 no ok after re-arm", int'(ok_flag_o), 0);
    check("R1 capture after re-arm", int'(err_cap_o), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule